// File: doc/BRIEF.md
# Memory Bank Select Decoder

This block decides whether one 16K-word memory bank owns the current transfer on an asynchronous backplane bus. The bus carries an 18-bit byte address, so bit 0 selects the byte and bit 1 selects between neighbouring words. The address and the bus handshake lines pass through synchronizers first. A range decoder then compares the upper address bits with a window taken from static configuration pins. When the bank is selected, a rising master-sync produces a one-cycle start pulse for the bank's timing chain. This happens only if the bus is not busy and the bank is not already in a cycle. The start also sets a busy flag, which holds until the timing chain reports that its cycle is complete.

The window can start on any 8K-word boundary. Normally it spans 16K words. In interleave mode, two banks are given the same start code and share a 32K-word window: one bank takes the even words and the other takes the odd words. Every window stops at 124K words, because the top 4K words belong to peripherals. Two extension options let the bank claim the lower 2K or the lower 3K words of that reserved page.

Top module: `membank_select`

## Requirements
- R1: With interleave off, bankSel is 1 exactly when the word address lies in [code*8K, min(code*8K+16K, 124K)). The word address is taken in 1K-word slices from byte-address bits 17..11, and code is the start code.
- R2: Word addresses from 124K to 128K-1 never select the bank while extension A is off. This holds whatever the state of extension B.
- R3: With extension A on and extension B off, word addresses from 124K to 126K-1 select the bank, and 126K to 128K-1 do not.
- R4: With extensions A and B both on, word addresses from 124K to 127K-1 select the bank, and 127K to 128K-1 do not.
- R5: With interleave on, the window is [code*8K, min(code*8K+32K, 124K)). A hit in the window, and also a hit in the extension region, needs byte-address bit 1 to equal the parity pin: 1 selects the odd bank and 0 the even bank.
- R6: All configuration pins are active low. The start code is the bitwise inverse of cfgStartN, and each option is on when its pin reads 0.
- R7: bankSel follows an address change after two rising clock edges and keeps its old value after only one edge.
- R8: startPulse is high for exactly one cycle, on the third rising edge after busMsyn rises. It fires only when bankSel is 1, busBusy is 0 and the bank is idle at that point.
- R9: bankBusy rises together with startPulse and stays high until cycleDone is sampled high. It clears on that edge. A master-sync rise while bankBusy is high produces no start.
- R10: Reset clears startPulse and bankBusy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 18 | Bus byte address, asynchronous |
| busMsyn | input | 1 | Bus master-sync strobe, asynchronous, active high |
| busBusy | input | 1 | Bus busy indication, asynchronous, active high |
| cycleDone | input | 1 | One-cycle completion strobe from the bank timing chain |
| cfgStartN | input | 4 | Inverted start code (8K-word units) |
| cfgIlvN | input | 1 | Interleave mode enable, active low |
| cfgOddN | input | 1 | Interleave parity, 0 makes this the odd bank |
| cfgExtAN | input | 1 | Extension A (124K to 126K-1), active low |
| cfgExtBN | input | 1 | Extension B (adds 126K to 127K-1 when A is on), active low |
| bankSel | output | 1 | Bank owns the synchronized address |
| startPulse | output | 1 | One-cycle timing-chain start |
| bankBusy | output | 1 | Bank cycle in progress |

## Verification
The bench builds the block with its default parameters: an 18-bit address, two synchronizer stages and extension support. With these values the decoded space is only 128 slices of 1K words. That is small enough to sweep every start code, both interleave parities and the non-interleaved mode against every slice, with both values of the word-select bit. The sweep reaches every window edge and the truncation at 124K. A narrower sweep around the reserved page tries all four extension settings in each mode. Directed sequences cover the start and busy interlock: a start refused because the bus is busy, a start refused because bankSel is 0, a second master-sync arriving while the bank is busy, and a reset while the bank is busy.

// File: rtl/membank_pkg.sv
package membank_pkg;

  localparam int CODE_W = 4;

  typedef struct packed {
    logic [CODE_W-1:0] startCode;
    logic              ilvOn;
    logic              oddBank;
    logic              extA;
    logic              extB;
  } bankCfg_t;

  typedef struct packed {
    logic launch;
    logic retire;
  } ctrlStrobe_t;

  function automatic bankCfg_t decodePins(input logic [CODE_W-1:0] startN,
                                          input logic ilvN, input logic oddN,
                                          input logic extAN, input logic extBN);
    bankCfg_t c;
    c.startCode = ~startN;
    c.ilvOn     = ~ilvN;
    c.oddBank   = ~oddN;
    c.extA      = ~extAN;
    c.extB      = ~extBN;
    return c;
  endfunction

endpackage

// File: rtl/membank_sync.sv
module membank_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/membank_window.sv
module membank_window
  import membank_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter bit EXT_SUPPORT = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  bankCfg_t          cfg,
  output logic              hit
);
  localparam int KW_LSB    = 11;               // 1K words = 2K bytes
  localparam int KW_W      = ADDR_W - KW_LSB;
  localparam int CW        = KW_W + 2;
  localparam int TOP_KW    = 1 << KW_W;
  localparam int RES_KW    = TOP_KW - 4;       // reserved peripheral page
  localparam int BLK_KW    = 8;
  localparam int NORM_SPAN = 2 * BLK_KW;
  localparam int ILV_SPAN  = 4 * BLK_KW;

  logic [CW-1:0] kw, winStart, winEndRaw, winEnd;
  logic          mainHit, extHit, parityOk;
  logic          unusedAddrBits;

  assign kw             = CW'(addr[ADDR_W-1:KW_LSB]);
  assign unusedAddrBits = ^{addr[KW_LSB-1:2], addr[0]};

  always_comb begin
    winStart  = CW'(cfg.startCode) * CW'(BLK_KW);
    winEndRaw = winStart + (cfg.ilvOn ? CW'(ILV_SPAN) : CW'(NORM_SPAN));
    winEnd    = (winEndRaw > CW'(RES_KW)) ? CW'(RES_KW) : winEndRaw;
    mainHit   = (kw >= winStart) && (kw < winEnd);
  end

  generate
    if (EXT_SUPPORT) begin : gExt
      logic [CW-1:0] extEnd;
      always_comb begin
        if (!cfg.extA)     extEnd = CW'(RES_KW);
        else if (cfg.extB) extEnd = CW'(RES_KW + 3);
        else               extEnd = CW'(RES_KW + 2);
        extHit = (kw >= CW'(RES_KW)) && (kw < extEnd);
      end
    end else begin : gNoExt
      logic unusedExtCfg;
      assign unusedExtCfg = cfg.extA ^ cfg.extB;
      assign extHit       = 1'b0;
    end
  endgenerate

  assign parityOk = !cfg.ilvOn || (addr[1] == cfg.oddBank);
  assign hit      = (mainHit || extHit) && parityOk;
endmodule

// File: rtl/membank_control.sv
module membank_control
  import membank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        msynS,
  input  logic        busBusyS,
  input  logic        bankSel,
  input  logic        bankBusy,
  input  logic        cycleDone,
  output ctrlStrobe_t strobe
);
  logic msynD;
  logic msynRise;

  always_ff @(posedge clk) begin
    if (!rstN) msynD <= 1'b0;
    else       msynD <= msynS;
  end

  assign msynRise      = msynS && !msynD;
  assign strobe.launch = msynRise && bankSel && !busBusyS && !bankBusy;
  assign strobe.retire = cycleDone && bankBusy;
endmodule

// File: rtl/membank_datapath.sv
module membank_datapath
  import membank_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int SYNC_STAGES = 2,
  parameter bit EXT_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busMsyn,
  input  logic              busBusy,
  input  bankCfg_t          cfg,
  input  ctrlStrobe_t       strobe,
  output logic              msynS,
  output logic              busBusyS,
  output logic              bankSel,
  output logic              startPulse,
  output logic              bankBusy
);
  logic [ADDR_W-1:0] addrS;
  logic [1:0]        ctlS;

  membank_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) u_addrSync (
    .clk(clk), .rstN(rstN), .d(busAddr), .q(addrS)
  );

  membank_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ctlSync (
    .clk(clk), .rstN(rstN), .d({busMsyn, busBusy}), .q(ctlS)
  );

  assign msynS    = ctlS[1];
  assign busBusyS = ctlS[0];

  membank_window #(.ADDR_W(ADDR_W), .EXT_SUPPORT(EXT_SUPPORT)) u_window (
    .addr(addrS), .cfg(cfg), .hit(bankSel)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPulse <= 1'b0;
      bankBusy   <= 1'b0;
    end else begin
      startPulse <= strobe.launch;
      if (strobe.launch)      bankBusy <= 1'b1;
      else if (strobe.retire) bankBusy <= 1'b0;
    end
  end
endmodule

// File: rtl/membank_select.sv
module membank_select
  import membank_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int SYNC_STAGES = 2,
  parameter bit EXT_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busMsyn,
  input  logic              busBusy,
  input  logic              cycleDone,
  input  logic [CODE_W-1:0] cfgStartN,
  input  logic              cfgIlvN,
  input  logic              cfgOddN,
  input  logic              cfgExtAN,
  input  logic              cfgExtBN,
  output logic              bankSel,
  output logic              startPulse,
  output logic              bankBusy
);
  bankCfg_t    cfg;
  ctrlStrobe_t strobe;
  logic        msynS, busBusyS;

  assign cfg = decodePins(cfgStartN, cfgIlvN, cfgOddN, cfgExtAN, cfgExtBN);

  membank_datapath #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .EXT_SUPPORT(EXT_SUPPORT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busMsyn(busMsyn),
    .busBusy(busBusy), .cfg(cfg), .strobe(strobe), .msynS(msynS),
    .busBusyS(busBusyS), .bankSel(bankSel), .startPulse(startPulse),
    .bankBusy(bankBusy)
  );

  membank_control u_ctl (
    .clk(clk), .rstN(rstN), .msynS(msynS), .busBusyS(busBusyS),
    .bankSel(bankSel), .bankBusy(bankBusy), .cycleDone(cycleDone),
    .strobe(strobe)
  );
endmodule

// File: rtl/membank_select_chk.sv
module membank_select_chk (
  input logic clk,
  input logic rstN,
  input logic bankSel,
  input logic startPulse,
  input logic bankBusy,
  input logic cycleDone
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse); // R8
  AST_START_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(bankSel)); // R8
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> bankBusy); // R9
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    bankBusy |=> !startPulse); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (bankBusy && !cycleDone) |=> bankBusy); // R9
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (bankBusy && cycleDone) |=> !bankBusy); // R9
endmodule

bind membank_select membank_select_chk u_chk (
  .clk(clk), .rstN(rstN), .bankSel(bankSel), .startPulse(startPulse),
  .bankBusy(bankBusy), .cycleDone(cycleDone)
);

// File: tb/sim_membank_select.sv
module sim_membank_select;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] busAddr = '0;
  logic        busMsyn = 1'b0;
  logic        busBusy = 1'b0;
  logic        cycleDone = 1'b0;
  logic [3:0]  cfgStartN = 4'hF;
  logic        cfgIlvN = 1'b1, cfgOddN = 1'b1, cfgExtAN = 1'b1, cfgExtBN = 1'b1;
  logic        bankSel, startPulse, bankBusy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  membank_select u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busMsyn(busMsyn),
    .busBusy(busBusy), .cycleDone(cycleDone), .cfgStartN(cfgStartN),
    .cfgIlvN(cfgIlvN), .cfgOddN(cfgOddN), .cfgExtAN(cfgExtAN),
    .cfgExtBN(cfgExtBN), .bankSel(bankSel), .startPulse(startPulse),
    .bankBusy(bankBusy)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b (addr=%h code=%0d)",
               req, act, exp, busAddr, 4'(~cfgStartN));
    end
  endtask

  // R6: configuration is driven through inverted pins
  task automatic setCfg(input int code, input int mode, input bit extA, input bit extB);
    cfgStartN = ~4'(code);
    cfgIlvN   = (mode == 0);
    cfgOddN   = !(mode == 2);
    cfgExtAN  = !extA;
    cfgExtBN  = !extB;
  endtask

  function automatic bit expSel(input int code, input int mode, input bit extA,
                                input bit extB, input int kw, input bit a01);
    int s = code * 8;
    int e = s + ((mode != 0) ? 32 : 16);
    bit m, x;
    if (e > 124) e = 124;
    m = (kw >= s) && (kw < e);
    x = extA && (kw >= 124) && (kw < (extB ? 127 : 126));
    return (m || x) && ((mode == 0) || (a01 == (mode == 2)));
  endfunction

  function automatic string tagOf(input int mode, input bit extA, input bit extB, input int kw);
    if (kw >= 124) begin
      if (!extA) return "R2";
      return extB ? "R4" : "R3";
    end
    return (mode != 0) ? "R5/R6" : "R1/R6";
  endfunction

  task automatic probe(input int code, input int mode, input bit extA,
                       input bit extB, input int kw, input bit a01);
    @(negedge clk);
    busAddr = {7'(kw), 9'(kw * 13 + 5), a01, 1'b1};
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(bankSel, expSel(code, mode, extA, extB, kw, a01), tagOf(mode, extA, extB, kw));
  endtask

  task automatic noStartFor(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(startPulse, 1'b0, req);
    end
  endtask

  task automatic raiseMsyn();
    @(negedge clk);
    busMsyn = 1'b1;
  endtask

  task automatic dropMsyn();
    @(negedge clk);
    busMsyn = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(startPulse, 1'b0, "R10 reset start");
    chk(bankBusy, 1'b0, "R10 reset busy");
    rstN = 1'b1;

    // Full sweep with no extension: R1, R2, R5, R6
    for (int code = 0; code < 16; code++)
      for (int mode = 0; mode < 3; mode++) begin
        setCfg(code, mode, 1'b0, 1'b0);
        for (int kw = 0; kw < 128; kw++)
          for (int a = 0; a < 2; a++) probe(code, mode, 1'b0, 1'b0, kw, a[0]);
      end

    // Extension sweep around the reserved page: R2, R3, R4, R5
    for (int ci = 0; ci < 3; ci++)
      for (int mode = 0; mode < 3; mode++)
        for (int ex = 0; ex < 4; ex++) begin
          int code = (ci == 0) ? 0 : (ci == 1 ? 14 : 15);
          setCfg(code, mode, ex[0], ex[1]);
          for (int kw = 116; kw < 128; kw++)
            for (int a = 0; a < 2; a++) probe(code, mode, ex[0], ex[1], kw, a[0]);
        end

    // R7: latency of two edges
    setCfg(0, 0, 1'b0, 1'b0);
    probe(0, 0, 1'b0, 1'b0, 5, 1'b0);
    @(negedge clk);
    busAddr = {7'd100, 11'd0};
    @(posedge clk); @(negedge clk);
    chk(bankSel, 1'b1, "R7 one edge keeps old");
    @(posedge clk); @(negedge clk);
    chk(bankSel, 1'b0, "R7 two edges new");
    busAddr = {7'd5, 11'd0};
    repeat (3) @(posedge clk);

    // R8/R9: normal start
    raiseMsyn();
    repeat (2) @(posedge clk); @(negedge clk);
    chk(startPulse, 1'b0, "R8 not before third edge");
    @(posedge clk); @(negedge clk);
    chk(startPulse, 1'b1, "R8 start on third edge");
    chk(bankBusy, 1'b1, "R9 busy with start");
    @(posedge clk); @(negedge clk);
    chk(startPulse, 1'b0, "R8 single cycle");
    noStartFor(4, "R8 no repeat while held");
    chk(bankBusy, 1'b1, "R9 busy held");

    // R9: second master-sync while busy
    dropMsyn();
    raiseMsyn();
    noStartFor(6, "R9 blocked while busy");
    chk(bankBusy, 1'b1, "R9 busy held without done");

    // R9: cycleDone releases
    @(negedge clk); cycleDone = 1'b1;
    @(posedge clk); @(negedge clk); cycleDone = 1'b0;
    chk(bankBusy, 1'b0, "R9 done clears busy");
    noStartFor(3, "R9 no start after release while held");
    dropMsyn();

    // R8: bus busy blocks
    busBusy = 1'b1;
    repeat (3) @(posedge clk);
    raiseMsyn();
    noStartFor(6, "R8 bus busy blocks");
    chk(bankBusy, 1'b0, "R8 bus busy leaves idle");
    dropMsyn();
    busBusy = 1'b0;

    // R8: unselected address blocks
    busAddr = {7'd100, 11'd0};
    repeat (3) @(posedge clk);
    raiseMsyn();
    noStartFor(6, "R8 unselected blocks");
    chk(bankBusy, 1'b0, "R8 unselected leaves idle");
    dropMsyn();

    // R10: reset while busy
    busAddr = {7'd5, 11'd0};
    repeat (3) @(posedge clk);
    raiseMsyn();
    repeat (3) @(posedge clk); @(negedge clk);
    chk(bankBusy, 1'b1, "R9 busy before reset");
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(bankBusy, 1'b0, "R10 reset clears busy");
    chk(startPulse, 1'b0, "R10 reset clears start");
    busMsyn = 1'b0;
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule